// File: doc/BRIEF.md
# Accumulator Data-Move Port

This block holds two 56-bit accumulators, A and B, and connects them to a 24-bit data bus for register moves. Each accumulator has three parts. The top part is an 8-bit extension byte, the middle part is a 24-bit high word and the bottom part is a 24-bit low word.

A move that names a whole accumulator is not a plain copy:
- On a write, the bus word goes into the high word. The extension byte is filled with copies of the word's sign bit, and the low word is cleared.
- On a read, the value is first scaled by the current scaling mode. It is then saturated to the 24-bit range, so an out-of-range value is never truncated.

A paired move treats the two high words as one 48-bit operand, and each half follows the same rules as a whole-accumulator move. The three parts of each accumulator can also be moved one at a time with no processing.

Reads are combinational from the current contents, and writes take effect on the rising clock edge. A sticky flag records that a read enabled by `rd_en` saturated. The flag is cleared by an explicit clear input or by reset.

Top module: `acc_move_port`

## Requirements
- R1: A synchronous reset clears both accumulators and the limit flag. After reset, every readable target returns zero and `limit_flag` is 0.
- R2: A write with `wr_sel`=3 (A) or 7 (B) works on the bus word `wr_data[23:0]`. The word is placed in the high word, the extension is filled with the word's bit 23, and the low word is cleared.
- R3: Writes to a single part change only that part. The part codes are 0 (A low word), 1 (A high word), 2 (A extension, from `wr_data[7:0]`), 4 (B low word), 5 (B high word) and 6 (B extension).
- R4: Reads of a single part (same codes as R3) are unscaled and unlimited. An extension byte is sign-extended to 24 bits on `rd_data[23:0]`. For every 24-bit read, `rd_data[47:24]` is zero.
- R5: A whole-accumulator read first scales by `scale`. Code 00 leaves the value unchanged. Code 01 is an arithmetic shift right by one. Code 10 is a shift left by one, with the low word's top bit entering the high word. Code 11 behaves as 00.
- R6: After scaling, the read returns bits 47..24. If bits 55..47 of the scaled value are not all equal, the read instead saturates to 0x7FFFFF for a positive value or 0x800000 for a negative value, and `limited` is 1.
- R7: `wr_sel`/`rd_sel`=8 selects the pair. Bits 47..24 map to A and bits 23..0 map to B. Each half is extended and filled on a write, and scaled and limited on a read.
- R8: `limit_flag` is set at a clock edge where `rd_en` is 1 and `limited` is 1. Once set, it holds until a cycle with `limit_clr` set. When a set and a clear happen in the same cycle, the set wins.
- R9: Select codes 9 to 15 are invalid. A write with one of these codes changes nothing, and a read with one returns zero.
- R10: Any write to A (codes 0 to 3) leaves B unchanged, and any write to B (codes 4 to 7) leaves A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scale | input | 2 | Scaling mode for whole-accumulator reads |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write target code |
| wr_data | input | 48 | Write data; single-word targets use bits 23..0 |
| rd_en | input | 1 | Marks a read that counts toward the limit flag |
| rd_sel | input | 4 | Read target code |
| rd_data | output | 48 | Read data; single-word targets drive bits 23..0 |
| limited | output | 1 | The current read is saturating |
| limit_clr | input | 1 | Clears the limit flag |
| limit_flag | output | 1 | Sticky record of a saturated read |

## Verification
The bench targets several corner cases:
- Only the extension byte disagrees with the high word's sign. A design that checks only the extension would miss saturation in the negative and positive cases built this way.
- Scaling up carries the low word's top bit into the result, and scaling down keeps the sign of a negative value. A logical shift or a dropped carry shows up as a wrong last digit or a wrong top digit.
- A paired read has one half in range and the other half out of range, which catches a limiter shared across both halves.
- A write and a read with invalid codes, a single-part write next to untouched parts, and a clear arriving in the same cycle as a new saturation. The last case exposes the wrong priority on the flag.

// File: rtl/acc_move_port.sv
module acc_move_port #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          scale,
  input  logic                wr_en,
  input  logic [3:0]          wr_sel,
  input  logic [2*WORD_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [3:0]          rd_sel,
  output logic [2*WORD_W-1:0] rd_data,
  output logic                limited,
  input  logic                limit_clr,
  output logic                limit_flag
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int TOP_W = EXT_W + 1;
  localparam logic [3:0] S_A0 = 4'd0, S_A1 = 4'd1, S_A2 = 4'd2, S_A = 4'd3,
                         S_B0 = 4'd4, S_B1 = 4'd5, S_B2 = 4'd6, S_B = 4'd7,
                         S_AB = 4'd8;
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_a, acc_b;

  function automatic logic [ACC_W-1:0] widen(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W:0] limit(input logic [ACC_W-1:0] v, input logic [1:0] sc);
    logic [ACC_W-1:0] s;
    logic [TOP_W-1:0] top;
    case (sc)
      2'b01:   s = {v[ACC_W-1], v[ACC_W-1:1]};
      2'b10:   s = {v[ACC_W-2:0], 1'b0};
      default: s = v;
    endcase
    top = s[ACC_W-1 -: TOP_W];
    if (&top || ~|top) return {1'b0, s[2*WORD_W-1:WORD_W]};
    return {1'b1, s[ACC_W-1] ? NEG_MAX : POS_MAX};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        S_A0: acc_a[WORD_W-1:0]          <= wr_data[WORD_W-1:0];
        S_A1: acc_a[2*WORD_W-1:WORD_W]   <= wr_data[WORD_W-1:0];
        S_A2: acc_a[ACC_W-1:2*WORD_W]    <= wr_data[EXT_W-1:0];
        S_A:  acc_a                      <= widen(wr_data[WORD_W-1:0]);
        S_B0: acc_b[WORD_W-1:0]          <= wr_data[WORD_W-1:0];
        S_B1: acc_b[2*WORD_W-1:WORD_W]   <= wr_data[WORD_W-1:0];
        S_B2: acc_b[ACC_W-1:2*WORD_W]    <= wr_data[EXT_W-1:0];
        S_B:  acc_b                      <= widen(wr_data[WORD_W-1:0]);
        S_AB: begin
          acc_a <= widen(wr_data[2*WORD_W-1:WORD_W]);
          acc_b <= widen(wr_data[WORD_W-1:0]);
        end
        default: ;
      endcase
    end
  end

  logic [WORD_W:0] lim_a, lim_b;
  assign lim_a = limit(acc_a, scale);
  assign lim_b = limit(acc_b, scale);

  always_comb begin
    rd_data = '0;
    limited = 1'b0;
    case (rd_sel)
      S_A0: rd_data[WORD_W-1:0] = acc_a[WORD_W-1:0];
      S_A1: rd_data[WORD_W-1:0] = acc_a[2*WORD_W-1:WORD_W];
      S_A2: rd_data[WORD_W-1:0] = {{(WORD_W-EXT_W){acc_a[ACC_W-1]}}, acc_a[ACC_W-1:2*WORD_W]};
      S_A:  {limited, rd_data[WORD_W-1:0]} = lim_a;
      S_B0: rd_data[WORD_W-1:0] = acc_b[WORD_W-1:0];
      S_B1: rd_data[WORD_W-1:0] = acc_b[2*WORD_W-1:WORD_W];
      S_B2: rd_data[WORD_W-1:0] = {{(WORD_W-EXT_W){acc_b[ACC_W-1]}}, acc_b[ACC_W-1:2*WORD_W]};
      S_B:  {limited, rd_data[WORD_W-1:0]} = lim_b;
      S_AB: begin
        rd_data = {lim_a[WORD_W-1:0], lim_b[WORD_W-1:0]};
        limited = lim_a[WORD_W] | lim_b[WORD_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) limit_flag <= 1'b0;
    else     limit_flag <= (limit_flag & ~limit_clr) | (rd_en & limited);
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (acc_a == '0 && acc_b == '0 && !limit_flag));

  p_whole_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == S_A) |=>
      acc_a == {{EXT_W{$past(wr_data[WORD_W-1])}}, $past(wr_data[WORD_W-1:0]), {WORD_W{1'b0}}});

  p_part_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == S_A0) |=> $stable(acc_a[ACC_W-1:WORD_W]));

  p_sat_value_r6: assert property (@(posedge clk) disable iff (rst)
    (limited && (rd_sel == S_A || rd_sel == S_B)) |->
      (rd_data[WORD_W-1:0] == POS_MAX || rd_data[WORD_W-1:0] == NEG_MAX));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (limit_flag && !limit_clr) |=> limit_flag);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && limited) |=> limit_flag);

  p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel > S_AB) |=> ($stable(acc_a) && $stable(acc_b)));

  p_isolate_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel <= S_A) |=> $stable(acc_b));
endmodule

// File: tb/acc_move_port_bench.sv
module acc_move_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  scale = 2'b00;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = 4'd0;
  logic [47:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_sel = 4'd0;
  logic [47:0] rd_data;
  logic        limited;
  logic        limit_clr = 1'b0;
  logic        limit_flag;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  acc_move_port u_acc_move_port (
    .clk(clk), .rst(rst), .scale(scale), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .limited(limited), .limit_clr(limit_clr), .limit_flag(limit_flag)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  ws;
    logic [47:0] wd;
    logic [3:0]  rs;
    logic [1:0]  sc;
    logic [47:0] exp;
    logic        lim;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd3,  48'h123456,       4'd3,  2'd0, 48'h123456,       1'b0}, // R2
    '{1'b1, 4'd3,  48'h800000,       4'd3,  2'd0, 48'h800000,       1'b0}, // R2
    '{1'b0, 4'd0,  48'h0,            4'd2,  2'd0, 48'hFFFFFF,       1'b0}, // R4 ext sign-extended
    '{1'b0, 4'd0,  48'h0,            4'd0,  2'd0, 48'h000000,       1'b0}, // R2 low cleared
    '{1'b1, 4'd1,  48'h400000,       4'd3,  2'd0, 48'h800000,       1'b1}, // R3 R6 neg sat
    '{1'b1, 4'd2,  48'h000001,       4'd3,  2'd0, 48'h7FFFFF,       1'b1}, // R3 R6 pos sat
    '{1'b1, 4'd3,  48'h400000,       4'd3,  2'd2, 48'h7FFFFF,       1'b1}, // R5 up overflows
    '{1'b0, 4'd0,  48'h0,            4'd3,  2'd1, 48'h200000,       1'b0}, // R5 down
    '{1'b0, 4'd0,  48'h0,            4'd3,  2'd3, 48'h400000,       1'b0}, // R5 code 11
    '{1'b1, 4'd3,  48'h200000,       4'd3,  2'd0, 48'h200000,       1'b0}, // R2
    '{1'b1, 4'd0,  48'h800000,       4'd3,  2'd2, 48'h400001,       1'b0}, // R5 carry from low
    '{1'b0, 4'd0,  48'h0,            4'd0,  2'd2, 48'h800000,       1'b0}, // R4 raw ignores scale
    '{1'b1, 4'd7,  48'hFFFFFF,       4'd7,  2'd0, 48'hFFFFFF,       1'b0}, // R2 on B
    '{1'b0, 4'd0,  48'h0,            4'd1,  2'd0, 48'h200000,       1'b0}, // R10 A untouched
    '{1'b1, 4'd8,  48'h123456876543, 4'd8,  2'd0, 48'h123456876543, 1'b0}, // R7
    '{1'b0, 4'd0,  48'h0,            4'd4,  2'd0, 48'h000000,       1'b0}, // R7 low cleared
    '{1'b0, 4'd0,  48'h0,            4'd6,  2'd0, 48'hFFFFFF,       1'b0}, // R7 ext filled
    '{1'b1, 4'd6,  48'h000000,       4'd8,  2'd0, 48'h1234567FFFFF, 1'b1}, // R7 one half sat
    '{1'b1, 4'd12, 48'hFFFFFFFFFFFF, 4'd3,  2'd0, 48'h123456,       1'b0}, // R9 bad write
    '{1'b0, 4'd0,  48'h0,            4'd13, 2'd0, 48'h000000,       1'b0}, // R9 bad read
    '{1'b0, 4'd0,  48'h0,            4'd5,  2'd0, 48'h876543,       1'b0}, // R4
    '{1'b1, 4'd3,  48'h800000,       4'd3,  2'd1, 48'hC00000,       1'b0}  // R5 down negative
  };

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 flag", {47'd0, limit_flag}, 48'd0);
    for (int s = 0; s < 9; s++) begin
      rd_sel = s[3:0];
      #1 check("R1 read", rd_data, 48'd0);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en   = VECS[i].wr;
      wr_sel  = VECS[i].ws;
      wr_data = VECS[i].wd;
      @(negedge clk);
      wr_en  = 1'b0;
      rd_sel = VECS[i].rs;
      scale  = VECS[i].sc;
      #1;
      check($sformatf("vector %0d data", i), rd_data, VECS[i].exp);
      check($sformatf("vector %0d limited", i), {47'd0, limited}, {47'd0, VECS[i].lim});
    end

    // Now A = FF_800000_000000 (in range), B = 00_876543_000000 (saturates)
    scale = 2'd0;
    check("R8 flag idle", {47'd0, limit_flag}, 48'd0);
    @(negedge clk);
    rd_sel = 4'd7; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 4'd3;
    #1 check("R8 flag set", {47'd0, limit_flag}, 48'd1);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1 check("R8 flag sticky", {47'd0, limit_flag}, 48'd1);
    @(negedge clk);
    limit_clr = 1'b1;
    @(negedge clk);
    limit_clr = 1'b0;
    #1 check("R8 flag cleared", {47'd0, limit_flag}, 48'd0);
    @(negedge clk);
    rd_sel = 4'd7; rd_en = 1'b1; limit_clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; limit_clr = 1'b0;
    #1 check("R8 set beats clear", {47'd0, limit_flag}, 48'd1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 flag after reset", {47'd0, limit_flag}, 48'd0);
    rd_sel = 4'd1;
    #1 check("R1 A high cleared", rd_data, 48'd0);
    rd_sel = 4'd5;
    #1 check("R1 B high cleared", rd_data, 48'd0);

    finish_run();
  end
endmodule